// File: doc/BRIEF.md
# Free Buffer Queue Fetch Manager

This block hands out free buffers to a reassembly engine. The buffers come from circular queues held in a shared 23-bit byte-addressed memory. There are two banks of queues, and each bank has its own 16-bit base field that is aligned to 128 bytes. For each request the block works out the byte address of the next entry from four things: the bank base, the queue number, the read index of that queue and the current entry size. It reads the first word of that entry, which is the buffer pointer, and returns it. It then advances the read index, wrapping at the programmed queue depth.

Each queue also counts the buffers taken from it. When that count reaches a programmable interval, the block raises a writeback request that carries the queue's new read index, so that the host can learn how far the consumer has read. A request to a queue whose read index equals the producer index supplied with the request is answered with an empty flag. Such a request reads nothing and leaves the index unchanged.

Top module: `fbq_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_req`, `buf_valid` and `wb_req` are 0. Every read index and every buffer count starts at 0.
- R2: With buffer return off, the read address is `(base << 7) + q*depth*8 + idx*8`, modulo 2^23. `base` is `base0` for bank 0 (`req_bank`=0) and `base1` for bank 1.
- R3: With `ret_en`=1, bank 0 queues 0..15 use 16-byte entries at `q*depth*16 + idx*16`. Bank 0 queues 16 and up start after that region, at `16*depth*16 + (q-16)*depth*8 + idx*8`. Bank 1 keeps the R2 layout.
- R4: `size_code` sets the depth to 64, 256, 1024 or 4096 (codes 0..3). The read index goes from depth-1 back to 0.
- R5: An accepted non-empty request holds `mem_rd_req` and a stable address until `mem_rd_ack`. In the next cycle `buf_valid`=1 with `buf_empty`=0 and `buf_ptr` equal to the data read, and the queue's index advances by one.
- R6: When the queue's read index equals `req_wr_idx`, the request gives `buf_valid`=1 with `buf_empty`=1 in the next cycle. No memory read is issued and the index does not change.
- R7: Each queue counts its own buffers. When the count reaches `upd_intv`, a writeback of {bank, queue, new index} is raised in the same cycle as `buf_valid`, and that count returns to 0.
- R8: `upd_intv`=0 raises a writeback after every buffer.
- R9: `wb_req` stays high with stable `wb_bank`, `wb_q` and `wb_idx` until `wb_ack`.
- R10: If a new writeback is due while an older one is unacknowledged, `req_ready` stays 0 until the older one is acknowledged, and the new one follows in the next cycle. If the acknowledge lands in the same cycle as the completing read, the new writeback is presented in the next cycle and `req_ready` returns to 1.
- R11: `req_ready` is 0 while a memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base0 | input | 16 | Bank 0 base, in 128-byte units |
| base1 | input | 16 | Bank 1 base, in 128-byte units |
| size_code | input | 2 | Queue depth code |
| ret_en | input | 1 | Buffer return mode for bank 0 |
| upd_intv | input | 8 | Buffers taken per writeback |
| req_valid | input | 1 | Buffer request |
| req_ready | output | 1 | Request accepted when high |
| req_bank | input | 1 | Bank of the request |
| req_q | input | QW | Queue of the request |
| req_wr_idx | input | 12 | Producer index of that queue |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 23 | Byte address of the entry |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | DW | First word of the entry |
| buf_valid | output | 1 | Response strobe |
| buf_empty | output | 1 | Queue was empty |
| buf_ptr | output | DW | Buffer pointer |
| wb_req | output | 1 | Writeback pending |
| wb_bank | output | 1 | Writeback bank |
| wb_q | output | QW | Writeback queue |
| wb_idx | output | 12 | Read index to publish |
| wb_ack | input | 1 | Writeback taken |

## Verification
A read can complete and need a new writeback in the same cycle as the host acknowledges the older writeback. The bench forces this case by holding the writeback acknowledge back and releasing it in the same cycle as the memory model's read acknowledge. It then expects the new writeback to appear in the following cycle, with no stall state and with `req_ready` high. A second run, in which the acknowledge comes later, checks that requests stay blocked until it arrives. In both runs the scoreboard checks that each writeback is delivered once, in order, with the correct index.

// File: rtl/fbq_fetch.sv
module fbq_fetch #(
  parameter int NQ = 32,
  parameter int DW = 32,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   base0,
  input  logic [15:0]   base1,
  input  logic [1:0]    size_code,
  input  logic          ret_en,
  input  logic [7:0]    upd_intv,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_bank,
  input  logic [QW-1:0] req_q,
  input  logic [11:0]   req_wr_idx,
  output logic          mem_rd_req,
  output logic [22:0]   mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [DW-1:0] mem_rd_data,
  output logic          buf_valid,
  output logic          buf_empty,
  output logic [DW-1:0] buf_ptr,
  output logic          wb_req,
  output logic          wb_bank,
  output logic [QW-1:0] wb_q,
  output logic [11:0]   wb_idx,
  input  logic          wb_ack
);
  localparam int NS = 2 * NQ;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WBWAIT} st_t;
  st_t st;

  logic          cb;
  logic [QW-1:0] cq;
  logic [11:0]   ridx [NS];
  logic [7:0]    cnt  [NS];

  wire [QW:0]  rslot = {req_bank, req_q};
  wire [QW:0]  cslot = {cb, cq};
  wire [11:0]  ci    = ridx[cslot];

  wire [11:0] dmask   = 12'((13'd64 << {size_code, 1'b0}) - 13'd1);
  wire [11:0] nxt_idx = (ci + 12'd1) & dmask;
  wire [7:0]  thr     = (upd_intv == 8'd0) ? 8'd1 : upd_intv;
  wire        cnt_hit = ({1'b0, cnt[cslot]} + 9'd1) >= {1'b0, thr};

  wire        big   = !cb && ret_en && (32'(cq) < 32'd16);
  wire [31:0] qslot = big ? 32'(cq) * 2 : ((!cb && ret_en) ? 32'(cq) + 32'd16 : 32'(cq));
  wire [31:0] off   = ((qslot << (6 + 2 * size_code)) + (32'(ci) << big)) << 3;
  wire [15:0] base  = cb ? base1 : base0;

  assign mem_rd_addr = 23'({base, 7'b0} + off);
  assign mem_rd_req  = (st == S_FETCH);
  assign req_ready   = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cb        <= 1'b0;
      cq        <= '0;
      buf_valid <= 1'b0;
      buf_empty <= 1'b0;
      buf_ptr   <= '0;
      wb_req    <= 1'b0;
      wb_bank   <= 1'b0;
      wb_q      <= '0;
      wb_idx    <= '0;
      for (int i = 0; i < NS; i++) begin
        ridx[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      buf_valid <= 1'b0;
      buf_empty <= 1'b0;
      if (wb_req && wb_ack) wb_req <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cb <= req_bank;
          cq <= req_q;
          if (ridx[rslot] == req_wr_idx) begin
            buf_valid <= 1'b1;
            buf_empty <= 1'b1;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rd_ack) begin
          buf_valid   <= 1'b1;
          buf_ptr     <= mem_rd_data;
          ridx[cslot] <= nxt_idx;
          st          <= S_IDLE;
          if (cnt_hit) begin
            cnt[cslot] <= '0;
            if (wb_req && !wb_ack) begin
              st <= S_WBWAIT;
            end else begin
              wb_req  <= 1'b1;
              wb_bank <= cb;
              wb_q    <= cq;
              wb_idx  <= nxt_idx;
            end
          end else begin
            cnt[cslot] <= cnt[cslot] + 8'd1;
          end
        end
        S_WBWAIT: if (wb_ack) begin
          wb_req  <= 1'b1;
          wb_bank <= cb;
          wb_q    <= cq;
          wb_idx  <= ci;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbq_fetch_chk.sv
module fbq_fetch_chk #(
  parameter int QW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd_req,
  input logic [22:0]   mem_rd_addr,
  input logic          mem_rd_ack,
  input logic          buf_valid,
  input logic          buf_empty,
  input logic          wb_req,
  input logic          wb_bank,
  input logic [QW-1:0] wb_q,
  input logic [11:0]   wb_idx,
  input logic          wb_ack
);
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  p_buf_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_ack |=> buf_valid && !buf_empty);

  p_empty_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && buf_empty |-> $past(req_valid && req_ready && !mem_rd_req));

  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable({wb_bank, wb_q, wb_idx}));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);
endmodule

bind fbq_fetch fbq_fetch_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
  .buf_valid(buf_valid), .buf_empty(buf_empty), .wb_req(wb_req),
  .wb_bank(wb_bank), .wb_q(wb_q), .wb_idx(wb_idx), .wb_ack(wb_ack));

// File: tb/fbq_fetch_tb.sv
`timescale 1ns/1ps
module fbq_fetch_tb;
  localparam int NQ = 32;
  localparam int QW = $clog2(NQ);

  logic clk = 0, rst_n = 0;
  logic [15:0] base0 = 0, base1 = 0;
  logic [1:0]  size_code = 0;
  logic        ret_en = 0;
  logic [7:0]  upd_intv = 0;
  logic        req_valid = 0, req_bank = 0;
  logic [QW-1:0] req_q = 0;
  logic [11:0] req_wr_idx = 0;
  logic        req_ready, mem_rd_req, mem_rd_ack = 0;
  logic [22:0] mem_rd_addr;
  logic [31:0] mem_rd_data = 0;
  logic        buf_valid, buf_empty;
  logic [31:0] buf_ptr;
  logic        wb_req, wb_bank, wb_ack = 0;
  logic [QW-1:0] wb_q;
  logic [11:0] wb_idx;

  always #2 clk = ~clk;

  fbq_fetch #(.NQ(NQ), .DW(32)) u_dut (.*);

  int checks = 0, errors = 0;
  int midx [2][NQ];
  int mcnt [2][NQ];

  bit           exp_emp [$];
  logic [31:0]  exp_ptr [$];
  string        exp_tag [$];
  logic [17:0]  exp_wb  [$];
  string        wb_tag  [$];

  int mem_lat = 0, lat_cnt = 0;
  bit wb_hold = 0, wb_sync = 0;

  function automatic logic [31:0] mdata(input logic [22:0] a);
    return {9'h1A5, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit raised;
    raised = 0;
    if (buf_valid) begin
      if (exp_emp.size() == 0) chk(0, "R5 unexpected response", 1, 0);
      else begin
        bit e; logic [31:0] p; string t;
        e = exp_emp.pop_front(); p = exp_ptr.pop_front(); t = exp_tag.pop_front();
        chk(buf_empty == e, {t, " empty flag"}, buf_empty, e);
        if (!e) chk(buf_ptr == p, {t, " pointer/address"}, buf_ptr, p);
      end
    end
    if (mem_rd_ack) mem_rd_ack = 0;
    else if (mem_rd_req) begin
      if (lat_cnt >= mem_lat) begin
        mem_rd_ack = 1; mem_rd_data = mdata(mem_rd_addr); lat_cnt = 0; raised = 1;
      end else lat_cnt++;
    end
    if (wb_ack) wb_ack = 0;
    else if (wb_req && (!wb_hold || (wb_sync && raised))) begin
      wb_ack = 1;
      if (exp_wb.size() == 0) chk(0, "R7 unexpected writeback", 1, 0);
      else begin
        logic [17:0] w; string t;
        w = exp_wb.pop_front(); t = wb_tag.pop_front();
        chk({wb_bank, 5'(wb_q), wb_idx} == w, {t, " writeback fields"}, {wb_bank, 5'(wb_q), wb_idx}, w);
      end
    end
  end

  task automatic fetch(input int b, input int q, input bit mk_empty, input string tag);
    int depth, thr, idx, off;
    logic [22:0] a;
    depth = 64 << (2 * size_code);
    idx = midx[b][q];
    while (!req_ready) @(negedge clk);
    req_bank = b[0]; req_q = q[QW-1:0];
    req_wr_idx = mk_empty ? 12'(idx) : 12'(idx ^ 1);
    if (mk_empty) begin
      exp_emp.push_back(1); exp_ptr.push_back(0); exp_tag.push_back(tag);
    end else begin
      if (b == 0 && ret_en && q < 16) off = q * depth * 16 + idx * 16;
      else if (b == 0 && ret_en) off = 16 * depth * 16 + (q - 16) * depth * 8 + idx * 8;
      else off = q * depth * 8 + idx * 8;
      a = 23'(((b == 0 ? int'(base0) : int'(base1)) * 128) + off);
      exp_emp.push_back(0); exp_ptr.push_back(mdata(a)); exp_tag.push_back(tag);
      midx[b][q] = (idx + 1) % depth;
      mcnt[b][q]++;
      thr = (upd_intv == 0) ? 1 : int'(upd_intv);
      if (mcnt[b][q] >= thr) begin
        mcnt[b][q] = 0;
        exp_wb.push_back({b[0], q[4:0], 12'(midx[b][q])});
        wb_tag.push_back(tag);
      end
    end
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (exp_emp.size() != 0) @(negedge clk);
  endtask

  task automatic drain_wb();
    while (exp_wb.size() != 0 || wb_req) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (midx[i, j]) begin midx[i][j] = 0; mcnt[i][j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(mem_rd_req == 0, "R1 mem_rd_req", mem_rd_req, 0);
    chk(buf_valid == 0, "R1 buf_valid", buf_valid, 0);
    chk(wb_req == 0, "R1 wb_req", wb_req, 0);

    base0 = 16'h0012; base1 = 16'h0400; size_code = 0; upd_intv = 3;
    fetch(0, 0, 1, "R1 first index zero / R6 empty");
    for (int i = 0; i < 4; i++) begin
      mem_lat = i;
      fetch(0, 3, 0, "R2 bank0 q3");
      fetch(1, 7, 0, "R2 bank1 q7");
    end
    fetch(1, 7, 1, "R6 empty no advance");
    fetch(1, 7, 0, "R6 index held after empty");
    for (int i = 0; i < 3; i++) fetch(0, 9, 0, "R7 per-queue count q9");
    fetch(0, 3, 0, "R7 per-queue count q3");
    drain_wb();

    mem_lat = 0; upd_intv = 200;
    for (int i = 0; i < 66; i++) fetch(1, 31, 0, "R4 wrap depth 64");
    size_code = 1;
    for (int i = 0; i < 258; i++) fetch(0, 1, 0, "R4 wrap depth 256");
    size_code = 2; fetch(1, 2, 0, "R4 depth 1024 layout");
    size_code = 3; fetch(1, 3, 0, "R4 depth 4096 layout");
    drain_wb();

    size_code = 0; ret_en = 1; upd_intv = 8;
    fetch(0, 2, 0, "R3 bank0 wide entry");
    fetch(0, 15, 0, "R3 bank0 last wide queue");
    fetch(0, 20, 0, "R3 bank0 narrow after wide");
    fetch(1, 2, 0, "R3 bank1 unaffected");
    ret_en = 0; drain_wb();

    upd_intv = 0;
    for (int i = 0; i < 3; i++) fetch(1, 4, 0, "R8 interval zero");
    drain_wb();

    upd_intv = 1; wb_hold = 1; mem_lat = 2;
    fetch(0, 6, 0, "R9 held writeback A");
    repeat (3) @(negedge clk);
    chk(wb_req == 1, "R9 wb_req held", wb_req, 1);
    fetch(0, 6, 0, "R10 second writeback B");
    @(negedge clk);
    chk(req_ready == 0, "R10 blocked while older writeback pending", req_ready, 0);
    chk(mem_rd_req == 0, "R11 no read while blocked", mem_rd_req, 0);
    wb_hold = 0;
    drain_wb();
    @(negedge clk);
    chk(req_ready == 1, "R10 ready after release", req_ready, 1);

    wb_hold = 1; wb_sync = 0; mem_lat = 0;
    fetch(1, 9, 0, "R10 sync writeback A");
    wb_sync = 1;
    fetch(1, 9, 0, "R10 sync writeback B");
    chk(req_ready == 1, "R10 same-cycle ack keeps ready", req_ready, 1);
    chk(wb_req == 1 && wb_idx == 12'(midx[1][9]), "R10 new writeback without gap",
        {wb_req, wb_idx}, {1'b1, 12'(midx[1][9])});
    wb_sync = 0; wb_hold = 0;
    drain_wb();

    repeat (4) @(negedge clk);
    chk(exp_emp.size() == 0 && exp_wb.size() == 0, "R7 scoreboard drained",
        exp_emp.size() + exp_wb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule